// File: doc/BRIEF.md
# Halt Mode Wake-up Sequencer

This block tracks whether the processor core is halted and decides how the core continues after the halt ends. A halt request from the running core puts the block into halt. While halted, four kinds of event can end the halt: an external reset, a watchdog overflow, a newly raised interrupt request, and a falling edge on any port pin whose wake-mask bit is set. An interrupt that was already pending when the halt began cannot end it.

Any wake event starts a fixed stall of 1024 system clock cycles. This stall lets the oscillator settle. When the stall ends, the block gives a one-cycle resume strobe and a resume code. The code tells the core to do one of four things: continue at the next instruction, take the interrupt, do a warm reset of only the program counter and stack pointer, or do a full initialization. The core's own logic carries out the chosen action. Gating the oscillator, interrupt vectoring and the program counter are outside this block.

Top module: `halt_wake_seq`

## Requirements
- R1: While the block is running (`halted` and `stalling` both low), `haltReq` raises `halted` on the next cycle. While halted or stalling, `haltReq` has no effect.
- R2: While halted, `extRst` causes a wake. It has the highest priority, and the resume code is 3 (full initialization).
- R3: While halted and without `extRst`, `wdtOvf` causes a wake with resume code 2 (warm reset). It takes precedence over interrupt and port causes.
- R4: While halted, a bit of `irqFlags` that was low when the halt began and is now high causes a wake. With no reset or watchdog cause, the resume code is 1 (take interrupt) when `irqEnable` is high and `stackFull` is low, and 0 (next instruction) otherwise.
- R5: An `irqFlags` bit that was already high in the cycle the halt request was accepted does not wake the block. The block stays halted.
- R6: While halted, port pin i causes a wake when it falls from 1 to 0 between consecutive clocks and `wakeMask[i]` is 1. This cause alone gives resume code 0. Rising edges and falling edges on masked-off pins do not wake the block.
- R7: `stalling` is high for exactly 1024 cycles, starting the cycle after the wake event is sampled. In the cycle after the last stall cycle, `resumeValid` is high for one cycle, `resumeAct` carries the resume code, and the block is running again.
- R8: During the stall, wake inputs and `haltReq` do not change the stall length or the resume code.
- R9: After reset, `halted`, `stalling` and `resumeValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| haltReq | input | 1 | Halt request from the core |
| portIn | input | 8 | Current port pin levels |
| wakeMask | input | 8 | Per-pin falling-edge wake enable |
| irqFlags | input | 4 | Interrupt request flags |
| irqEnable | input | 1 | Interrupt enable |
| stackFull | input | 1 | Return stack is full |
| wdtOvf | input | 1 | Watchdog overflow |
| extRst | input | 1 | External reset request |
| halted | output | 1 | Block is in halt |
| stalling | output | 1 | Post-wake stall in progress |
| resumeValid | output | 1 | One-cycle resume strobe |
| resumeAct | output | 2 | Resume code: 0 next, 1 interrupt, 2 warm, 3 full init |

## Verification
The hardest case to reach from the ports is a halt that must not end. The inputs change, but only in ways that should be ignored: a flag that was already pending at halt entry, a rising edge, or a falling edge on a masked-off pin. Each trial fixes the flag and port values before the halt begins. It then applies a random set of new values in a single cycle. The bench works out from the snapshot whether a wake should follow. When no wake is expected, it checks that the block is still halted several cycles later, and then ends the halt with an external reset. Some trials also toggle every input in the middle of the stall to show that neither the stall length nor the resume code changes.

// File: rtl/hws_pkg.sv
package hws_pkg;
  typedef enum logic [1:0] {
    ACT_NEXT = 2'd0,
    ACT_IRQ  = 2'd1,
    ACT_WARM = 2'd2,
    ACT_COLD = 2'd3
  } resumeAct_t;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HALT  = 2'd1,
    ST_STALL = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic armLatch;
    logic cntClr;
    logic cntInc;
  } dpCtl_t;

  // wake causes seen by the datapath this cycle
  typedef struct packed {
    logic ext;
    logic wdt;
    logic irq;
    logic port;
  } wakeCause_t;
endpackage

// File: rtl/hws_datapath.sv
module hws_datapath
  import hws_pkg::*;
#(
  parameter int PORT_W       = 8,
  parameter int IRQ_W        = 4,
  parameter int STALL_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [PORT_W-1:0] portIn,
  input  logic [PORT_W-1:0] wakeMask,
  input  logic [IRQ_W-1:0]  irqFlags,
  input  logic              extRst,
  input  logic              wdtOvf,
  output wakeCause_t        cause,
  output logic              cntDone
);
  localparam int CNT_W = $clog2(STALL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STALL_CYCLES - 1);

  logic [PORT_W-1:0] portPrev;
  logic [IRQ_W-1:0]  irqArmed;
  logic [CNT_W-1:0]  stallCnt;
  logic [PORT_W-1:0] pinFell;

  // previous-cycle copy of the pins; ones at reset so no false edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) portPrev <= '1;
    else       portPrev <= portIn;
  end

  // flags low at halt entry are the only ones allowed to wake
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             irqArmed <= '0;
    else if (ctl.armLatch) irqArmed <= ~irqFlags;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           stallCnt <= '0;
    else if (ctl.cntClr) stallCnt <= '0;
    else if (ctl.cntInc) stallCnt <= stallCnt + 1'b1;
  end

  for (genvar i = 0; i < PORT_W; i++) begin : g_pinEdge
    assign pinFell[i] = portPrev[i] & ~portIn[i] & wakeMask[i];
  end

  always_comb begin
    cause.ext  = extRst;
    cause.wdt  = wdtOvf;
    cause.irq  = |(irqFlags & irqArmed);
    cause.port = |pinFell;
  end

  assign cntDone = (stallCnt == CNT_LAST);
endmodule

// File: rtl/hws_control.sv
module hws_control
  import hws_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       haltReq,
  input  wakeCause_t cause,
  input  logic       cntDone,
  input  logic       irqEnable,
  input  logic       stackFull,
  output dpCtl_t     ctl,
  output logic       halted,
  output logic       stalling,
  output logic       resumeValid,
  output logic [1:0] resumeAct
);
  seqState_t  state, stateNext;
  resumeAct_t actReg, actPick;
  logic       anyWake, finish;

  assign anyWake = cause.ext | cause.wdt | cause.irq | cause.port;
  assign finish  = (state == ST_STALL) && cntDone;

  // fixed priority: reset, watchdog, interrupt, port
  always_comb begin
    if (cause.ext)      actPick = ACT_COLD;
    else if (cause.wdt) actPick = ACT_WARM;
    else if (cause.irq) actPick = (irqEnable && !stackFull) ? ACT_IRQ : ACT_NEXT;
    else                actPick = ACT_NEXT;
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_RUN: if (haltReq) begin
        stateNext    = ST_HALT;
        ctl.armLatch = 1'b1;
      end
      ST_HALT: if (anyWake) begin
        stateNext  = ST_STALL;
        ctl.cntClr = 1'b1;
      end
      ST_STALL: begin
        ctl.cntInc = 1'b1;
        if (cntDone) stateNext = ST_RUN;
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_RUN;
      actReg      <= ACT_NEXT;
      resumeValid <= 1'b0;
    end else begin
      state       <= stateNext;
      resumeValid <= finish;
      if (state == ST_HALT && anyWake) actReg <= actPick;
    end
  end

  assign halted    = (state == ST_HALT);
  assign stalling  = (state == ST_STALL);
  assign resumeAct = actReg;
endmodule

// File: rtl/halt_wake_seq.sv
module halt_wake_seq
  import hws_pkg::*;
#(
  parameter int PORT_W       = 8,
  parameter int IRQ_W        = 4,
  parameter int STALL_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              haltReq,
  input  logic [PORT_W-1:0] portIn,
  input  logic [PORT_W-1:0] wakeMask,
  input  logic [IRQ_W-1:0]  irqFlags,
  input  logic              irqEnable,
  input  logic              stackFull,
  input  logic              wdtOvf,
  input  logic              extRst,
  output logic              halted,
  output logic              stalling,
  output logic              resumeValid,
  output logic [1:0]        resumeAct
);
  dpCtl_t     ctl;
  wakeCause_t causeRaw, cause;
  logic       cntDone;

  hws_datapath #(
    .PORT_W(PORT_W), .IRQ_W(IRQ_W), .STALL_CYCLES(STALL_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .portIn(portIn),
    .wakeMask(wakeMask), .irqFlags(irqFlags), .extRst(extRst),
    .wdtOvf(wdtOvf), .cause(causeRaw), .cntDone(cntDone)
  );

  // wake causes only count while halted
  assign cause = halted ? causeRaw : '0;

  hws_control u_ctl (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .cause(cause),
    .cntDone(cntDone), .irqEnable(irqEnable), .stackFull(stackFull),
    .ctl(ctl), .halted(halted), .stalling(stalling),
    .resumeValid(resumeValid), .resumeAct(resumeAct)
  );
endmodule

// File: rtl/halt_wake_seq_chk.sv
module halt_wake_seq_chk #(
  parameter int STALL_CYCLES = 1024
) (
  input logic       clk,
  input logic       rstN,
  input logic       haltReq,
  input logic       wdtOvf,
  input logic       extRst,
  input logic       halted,
  input logic       stalling,
  input logic       resumeValid
);
  localparam int LEN_W = $clog2(STALL_CYCLES + 2);
  logic [LEN_W-1:0] stallLen;
  logic             stallSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stallLen  <= '0;
      stallSeen <= 1'b0;
    end else begin
      stallSeen <= stalling;
      if (stalling && !stallSeen) stallLen <= LEN_W'(1);
      else if (stalling)          stallLen <= stallLen + 1'b1;
    end
  end

  // R1
  halt_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!halted && !stalling && haltReq) |=> halted);

  // R2
  ext_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (halted && extRst) |=> stalling);

  // R3
  wdt_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (halted && wdtOvf) |=> stalling);

  // R7
  resume_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    resumeValid |-> (stallLen == LEN_W'(STALL_CYCLES)));

  // R7
  resume_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resumeValid |=> !resumeValid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stalling |=> (stalling || resumeValid));

  // R9
  state_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(halted && stalling));
endmodule

bind halt_wake_seq halt_wake_seq_chk #(.STALL_CYCLES(STALL_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .haltReq(haltReq), .wdtOvf(wdtOvf),
  .extRst(extRst), .halted(halted), .stalling(stalling),
  .resumeValid(resumeValid)
);

// File: tb/halt_wake_seq_bench.sv
module halt_wake_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STALL = 1024;
  localparam int WATCHDOG = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       haltReq = 1'b0;
  logic [7:0] portIn = 8'hFF;
  logic [7:0] wakeMask = 8'h00;
  logic [3:0] irqFlags = 4'h0;
  logic       irqEnable = 1'b0;
  logic       stackFull = 1'b0;
  logic       wdtOvf = 1'b0;
  logic       extRst = 1'b0;
  logic       halted, stalling, resumeValid;
  logic [1:0] resumeAct;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halt_wake_seq u_halt_wake_seq (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .portIn(portIn),
    .wakeMask(wakeMask), .irqFlags(irqFlags), .irqEnable(irqEnable),
    .stackFull(stackFull), .wdtOvf(wdtOvf), .extRst(extRst),
    .halted(halted), .stalling(stalling), .resumeValid(resumeValid),
    .resumeAct(resumeAct)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit expWake(input bit ext, input bit wdt, input logic [3:0] f0,
                                 input logic [3:0] f1, input logic [7:0] p0,
                                 input logic [7:0] p1, input logic [7:0] mask);
    return ext || wdt || |(f1 & ~f0) || |(p0 & ~p1 & mask);
  endfunction

  function automatic int expAct(input bit ext, input bit wdt, input logic [3:0] f0,
                                input logic [3:0] f1, input bit ien, input bit sfull);
    if (ext) return 3;
    if (wdt) return 2;
    if (|(f1 & ~f0)) return (ien && !sfull) ? 1 : 0;
    return 0;
  endfunction

  // wait for the resume strobe, counting cycles from the wake edge
  task automatic waitResume(input int act, input bit disturb, input string req);
    int k = 0;
    check(stalling === 1'b1, "R7 stall start", int'(stalling), 1);
    while (resumeValid !== 1'b1 && k < STALL + 5) begin
      @(negedge clk);
      k++;
      if (disturb && k == 100) begin
        extRst = 1'b1; wdtOvf = 1'b1; haltReq = 1'b1;
        irqFlags = 4'hF; portIn = 8'h00;
      end
      if (disturb && k == 101) begin
        extRst = 1'b0; wdtOvf = 1'b0; haltReq = 1'b0;
      end
    end
    check(k == STALL, disturb ? "R8 stall length" : "R7 stall length", k, STALL);
    check(int'(resumeAct) == act, req, int'(resumeAct), act);
    check(!halted && !stalling, "R7 running after resume",
          int'({halted, stalling}), 0);
    @(negedge clk);
    check(resumeValid === 1'b0, "R7 one-cycle strobe", int'(resumeValid), 0);
  endtask

  task automatic trial(input logic [3:0] f0, input logic [7:0] p0, input logic [7:0] mask,
                       input bit ext, input bit wdt, input logic [3:0] f1,
                       input logic [7:0] p1, input bit ien, input bit sfull,
                       input bit disturb);
    bit w;
    int a;
    string req;
    irqFlags = f0; portIn = p0; wakeMask = mask;
    irqEnable = ien; stackFull = sfull;
    @(negedge clk);
    haltReq = 1'b1;
    @(negedge clk);
    haltReq = 1'b0;
    check(halted === 1'b1, "R1 halt entry", int'(halted), 1);
    repeat (3) @(negedge clk);
    check(halted === 1'b1, "R5 stay halted with stable inputs", int'(halted), 1);
    w = expWake(ext, wdt, f0, f1, p0, p1, mask);
    a = expAct(ext, wdt, f0, f1, ien, sfull);
    extRst = ext; wdtOvf = wdt; irqFlags = f1; portIn = p1;
    @(negedge clk);
    extRst = 1'b0; wdtOvf = 1'b0;
    if (!w) begin
      repeat (4) @(negedge clk);
      check(halted === 1'b1 && stalling === 1'b0, "R5/R6 no wake (R5 R6)",
            int'(halted), 1);
      extRst = 1'b1;
      @(negedge clk);
      extRst = 1'b0;
      a = 3;
    end
    req = (a == 3) ? "R2 resume code" : (a == 2) ? "R3 resume code" :
          (a == 1) ? "R4 resume code" : (|(f1 & ~f0) ? "R4 resume code" : "R6 resume code");
    waitResume(a, disturb, req);
    irqFlags = 4'h0; portIn = 8'hFF;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(halted === 1'b0 && stalling === 1'b0 && resumeValid === 1'b0,
          "R9 reset state", int'({halted, stalling, resumeValid}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(halted === 1'b0 && stalling === 1'b0 && resumeValid === 1'b0,
          "R9 idle after reset", int'({halted, stalling, resumeValid}), 0);

    // directed: R2 all causes together
    trial(4'h0, 8'hFF, 8'hFF, 1, 1, 4'hF, 8'h00, 1, 0, 0);
    // R3 watchdog beats interrupt and port
    trial(4'h0, 8'hFF, 8'hFF, 0, 1, 4'h1, 8'h00, 1, 0, 0);
    // R4 interrupt taken
    trial(4'h0, 8'h00, 8'h00, 0, 0, 4'h2, 8'h00, 1, 0, 0);
    // R4 interrupt with stack full -> next instruction
    trial(4'h0, 8'h00, 8'h00, 0, 0, 4'h4, 8'h00, 1, 1, 0);
    // R4 interrupt disabled -> next instruction
    trial(4'h0, 8'h00, 8'h00, 0, 0, 4'h8, 8'h00, 0, 0, 0);
    // R5 flag pending at halt entry cannot wake
    trial(4'h3, 8'h00, 8'h00, 0, 0, 4'h3, 8'h00, 1, 0, 0);
    // R6 enabled falling edge
    trial(4'h0, 8'h10, 8'h10, 0, 0, 4'h0, 8'h00, 1, 0, 0);
    // R6 masked falling edge and rising edge do not wake
    trial(4'h0, 8'h0F, 8'hF0, 0, 0, 4'h0, 8'hF0, 1, 0, 0);
    // R8 disturbance during stall
    trial(4'h0, 8'h01, 8'h01, 0, 0, 4'h0, 8'h00, 0, 0, 1);

    for (int t = 0; t < 24; t++) begin
      logic [3:0] f0, f1;
      logic [7:0] p0, p1, m;
      f0 = 4'($urandom);
      f1 = f0 | (($urandom % 3 == 0) ? 4'($urandom) : 4'h0);
      p0 = 8'($urandom);
      p1 = 8'($urandom);
      m  = 8'($urandom);
      trial(f0, p0, m, ($urandom % 6) == 0, ($urandom % 5) == 0, f1, p1,
            1'($urandom), 1'($urandom), (t % 7) == 3);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule